// File: doc/BRIEF.md
# DMA Peripheral Trigger Handshake Unit

This unit sits between a handful of peripheral event flags and the request input of a single DMA channel. It holds the receive and transmit flags of a serial bus interface, a bank of converter result flags and the data-request flag of a waveform output module. A source selector picks one of them, and the unit issues a single-cycle DMA request when that source becomes ready. Each flag clears itself when the DMA completes the matching access. The bus flags clear on the DMA acknowledge. A converter result flag clears when the DMA reads that result register. The waveform flag clears when the DMA writes the waveform data register.

Converter triggering follows the converter's sequence mode. In the single-result modes (sequence mode 0 or 2), any result flag that is set raises a trigger. In the sequence modes (1 or 3), only the flag of the last result register of the sequence raises a trigger. The mode and the end index are captured when a sequence starts. A separate gate lets a DMA write to the flash region proceed only when the flash controller is set up and not busy. Otherwise the write is held.

The trigger sequencer has three states. ST_ARMED waits for the selected, qualified flag. ST_PULSE drives the request for one cycle. ST_PENDING waits for the DMA to clear the selected source. The transitions are as follows. ST_ARMED goes to ST_PULSE when the qualified flag is high. ST_PULSE goes to ST_ARMED if the selected source is cleared, or its qualified flag drops, in that cycle; otherwise it goes to ST_PENDING. ST_PENDING goes to ST_ARMED on a clear of the selected source or when its qualified flag drops.

Top module: `dma_trig_hub`

## Requirements
- R1: After reset all flags, `dma_req`, `fl_wr_go` and `fl_wr_hold` are 0.
- R2: With `trig_sel`=0 (bus receive) and `bus_rx_ie`=0, a `bus_rx_set` pulse sets `rx_flag` at the next edge. `dma_req` goes high for exactly one cycle, one cycle after the flag rises.
- R3: With `trig_sel`=1 (bus transmit) and `bus_tx_ie`=0, a `bus_tx_set` pulse gives the same one-cycle request through `tx_flag`.
- R4: While the interrupt enable of the selected bus flag is 1, that flag stays set but raises no request. Clearing the enable while the flag is still set raises the request in the cycle after the enable falls.
- R5: `dma_ack` clears only the bus flag of the currently selected source (`trig_sel` 0 or 1). It leaves the other bus flag, the converter flags and the waveform flag unchanged.
- R6: When a set and a clear reach the same flag in one cycle, the flag stays set, and a new one-cycle request follows two cycles later.
- R7: With `trig_sel`=2 (converter) and a captured `cnv_seq_multi`=0, any set converter result flag raises a request.
- R8: With a captured `cnv_seq_multi`=1, only `cnv_flag[end]` raises a request, where end is the captured `cnv_seq_end`. Other result flags stay set without triggering.
- R9: `cnv_seq_multi` and `cnv_seq_end` take effect only at a `cnv_seq_start` pulse. Changing them at any other time does not alter triggering.
- R10: `dma_rd_res` clears only `cnv_flag[dma_res_idx]`; all other result flags are untouched.
- R11: With `trig_sel`=3 (waveform), `wav_flag` raises a request. It clears on `dma_wr_wav` and not on `dma_ack`.
- R12: `fl_wr_go` = `fl_wr_req` & `fl_ready` & !`fl_busy`, combinationally. `fl_wr_hold` is 1 when a flash write is requested but not allowed to go.
- R13: A source that stays set after its request raises no further request until the DMA clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_sel | input | 2 | Source select: 0 bus rx, 1 bus tx, 2 converter, 3 waveform |
| bus_rx_set | input | 1 | Bus receive data ready event |
| bus_rx_ie | input | 1 | Bus receive interrupt enable (masks DMA trigger) |
| bus_tx_set | input | 1 | Bus transmit buffer empty event |
| bus_tx_ie | input | 1 | Bus transmit interrupt enable (masks DMA trigger) |
| dma_ack | input | 1 | DMA acknowledge of a bus transfer |
| cnv_res_set | input | NRES | Converter result written, one bit per result register |
| cnv_seq_start | input | 1 | Converter sequence start; captures mode and end index |
| cnv_seq_multi | input | 1 | 1 for sequence modes (1,3), 0 for single-result modes (0,2) |
| cnv_seq_end | input | IDXW | Index of last result register in a sequence |
| dma_rd_res | input | 1 | DMA reads a converter result register |
| dma_res_idx | input | IDXW | Index of the result register being read |
| wav_set | input | 1 | Waveform module needs new data |
| dma_wr_wav | input | 1 | DMA writes the waveform data register |
| fl_wr_req | input | 1 | DMA write aimed at flash |
| fl_ready | input | 1 | Flash controller set up for writing |
| fl_busy | input | 1 | Flash controller busy |
| dma_req | output | 1 | One-cycle DMA trigger |
| rx_flag | output | 1 | Bus receive flag |
| tx_flag | output | 1 | Bus transmit flag |
| cnv_flag | output | NRES | Converter result flags |
| wav_flag | output | 1 | Waveform data flag |
| fl_wr_go | output | 1 | Flash write may proceed |
| fl_wr_hold | output | 1 | Flash write held |

## Verification
The bench drives a set and a DMA clear into the same flag in one cycle. A design that let the clear win would drop the event and never issue the second request. It keeps a flag set after its request and watches for repeats. An edge detector that re-fires, or a level-driven request, would show up as extra pulses. It runs the converter in sequence mode with a non-final result flag set, and it changes the mode inputs without a start pulse. A design that ignored the captured mode would trigger early on the wrong result. It also acknowledges with another source selected, so that an acknowledge wrongly reaching an unselected flag is caught.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

    typedef enum logic [1:0] {
        SRC_BUS_RX = 2'd0,
        SRC_BUS_TX = 2'd1,
        SRC_CNV    = 2'd2,
        SRC_WAV    = 2'd3
    } trig_src_e;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_PULSE   = 2'd1,
        ST_PENDING = 2'd2
    } trig_st_e;

endpackage

// File: rtl/dma_trig_flag.sv
// Bank of self-clearing event flags; a set in the same cycle as a clear wins.
module dma_trig_flag #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_i) | set_i;
        end
    end

endmodule

// File: rtl/dma_trig_cnv_qual.sv
// Captures the converter sequence setup and qualifies result flags for triggering.
module dma_trig_cnv_qual #(
    parameter int NRES = 16,
    localparam int IDXW = (NRES > 1) ? $clog2(NRES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seq_start_i,
    input  logic            seq_multi_i,
    input  logic [IDXW-1:0] seq_end_i,
    input  logic [NRES-1:0] flags_i,
    input  logic            rd_i,
    input  logic [IDXW-1:0] rd_idx_i,
    output logic            qual_o,
    output logic            clr_hit_o
);

    logic            multi_q;
    logic [IDXW-1:0] end_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            multi_q <= 1'b0;
            end_q   <= '0;
        end else if (seq_start_i) begin
            multi_q <= seq_multi_i;
            end_q   <= seq_end_i;
        end
    end

    always_comb begin
        if (multi_q) begin
            qual_o    = flags_i[end_q];
            clr_hit_o = rd_i && (rd_idx_i == end_q);
        end else begin
            qual_o    = |flags_i;
            clr_hit_o = rd_i && flags_i[rd_idx_i];
        end
    end

endmodule

// File: rtl/dma_trig_fsm.sv
// Request sequencer: one pulse per qualified event, re-armed by the DMA clear.
module dma_trig_fsm
    import dma_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qual_i,
    input  logic clr_i,
    output logic req_o
);

    trig_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (qual_i) state_d = ST_PULSE;
            ST_PULSE:   state_d = (clr_i || !qual_i) ? ST_ARMED : ST_PENDING;
            ST_PENDING: if (clr_i || !qual_i) state_d = ST_ARMED;
            default:    state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        req_o = (state_q == ST_PULSE);
    end

endmodule

// File: rtl/dma_trig_flash_gate.sv
// Lets a DMA flash write through only when the flash controller can take it.
module dma_trig_flash_gate (
    input  logic req_i,
    input  logic ready_i,
    input  logic busy_i,
    output logic go_o,
    output logic hold_o
);

    logic ok;

    always_comb begin
        ok     = ready_i && !busy_i;
        go_o   = req_i && ok;
        hold_o = req_i && !ok;
    end

endmodule

// File: rtl/dma_trig_hub.sv
module dma_trig_hub
    import dma_trig_pkg::*;
#(
    parameter int NRES = 16,
    localparam int IDXW = (NRES > 1) ? $clog2(NRES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      trig_sel,
    input  logic            bus_rx_set,
    input  logic            bus_rx_ie,
    input  logic            bus_tx_set,
    input  logic            bus_tx_ie,
    input  logic            dma_ack,
    input  logic [NRES-1:0] cnv_res_set,
    input  logic            cnv_seq_start,
    input  logic            cnv_seq_multi,
    input  logic [IDXW-1:0] cnv_seq_end,
    input  logic            dma_rd_res,
    input  logic [IDXW-1:0] dma_res_idx,
    input  logic            wav_set,
    input  logic            dma_wr_wav,
    input  logic            fl_wr_req,
    input  logic            fl_ready,
    input  logic            fl_busy,
    output logic            dma_req,
    output logic            rx_flag,
    output logic            tx_flag,
    output logic [NRES-1:0] cnv_flag,
    output logic            wav_flag,
    output logic            fl_wr_go,
    output logic            fl_wr_hold
);

    trig_src_e       src;
    logic            rx_clr, tx_clr;
    logic [NRES-1:0] cnv_clr;
    logic            cnv_qual, cnv_clr_hit;
    logic            sel_qual, sel_clr;

    assign src    = trig_src_e'(trig_sel);
    assign rx_clr = dma_ack && (src == SRC_BUS_RX);
    assign tx_clr = dma_ack && (src == SRC_BUS_TX);

    dma_trig_flag #(.W(1)) u_rx (
        .clk(clk), .rst_n(rst_n), .set_i(bus_rx_set), .clr_i(rx_clr), .q_o(rx_flag)
    );

    dma_trig_flag #(.W(1)) u_tx (
        .clk(clk), .rst_n(rst_n), .set_i(bus_tx_set), .clr_i(tx_clr), .q_o(tx_flag)
    );

    dma_trig_flag #(.W(1)) u_wav (
        .clk(clk), .rst_n(rst_n), .set_i(wav_set), .clr_i(dma_wr_wav), .q_o(wav_flag)
    );

    for (genvar i = 0; i < NRES; i++) begin : g_cnv_clr
        assign cnv_clr[i] = dma_rd_res && (dma_res_idx == IDXW'(i));
    end

    dma_trig_flag #(.W(NRES)) u_cnv (
        .clk(clk), .rst_n(rst_n), .set_i(cnv_res_set), .clr_i(cnv_clr), .q_o(cnv_flag)
    );

    dma_trig_cnv_qual #(.NRES(NRES)) u_cnv_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start_i(cnv_seq_start),
        .seq_multi_i(cnv_seq_multi),
        .seq_end_i  (cnv_seq_end),
        .flags_i    (cnv_flag),
        .rd_i       (dma_rd_res),
        .rd_idx_i   (dma_res_idx),
        .qual_o     (cnv_qual),
        .clr_hit_o  (cnv_clr_hit)
    );

    always_comb begin
        unique case (src)
            SRC_BUS_RX: begin sel_qual = rx_flag && !bus_rx_ie; sel_clr = dma_ack;     end
            SRC_BUS_TX: begin sel_qual = tx_flag && !bus_tx_ie; sel_clr = dma_ack;     end
            SRC_CNV:    begin sel_qual = cnv_qual;              sel_clr = cnv_clr_hit; end
            SRC_WAV:    begin sel_qual = wav_flag;              sel_clr = dma_wr_wav;  end
            default:    begin sel_qual = 1'b0;                  sel_clr = 1'b0;        end
        endcase
    end

    dma_trig_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .qual_i(sel_qual), .clr_i(sel_clr), .req_o(dma_req)
    );

    dma_trig_flash_gate u_flash (
        .req_i(fl_wr_req), .ready_i(fl_ready), .busy_i(fl_busy),
        .go_o(fl_wr_go), .hold_o(fl_wr_hold)
    );

endmodule

// File: rtl/dma_trig_hub_chk.sv
module dma_trig_hub_chk #(
    parameter int NRES = 16,
    localparam int IDXW = (NRES > 1) ? $clog2(NRES) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      trig_sel,
    input logic            bus_rx_set,
    input logic            bus_rx_ie,
    input logic            bus_tx_ie,
    input logic            dma_ack,
    input logic [NRES-1:0] cnv_res_set,
    input logic            dma_rd_res,
    input logic [IDXW-1:0] dma_res_idx,
    input logic            wav_set,
    input logic            dma_wr_wav,
    input logic            fl_wr_req,
    input logic            fl_ready,
    input logic            fl_busy,
    input logic            dma_req,
    input logic            rx_flag,
    input logic [NRES-1:0] cnv_flag,
    input logic            wav_flag,
    input logic            fl_wr_go,
    input logic            fl_wr_hold
);

    a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    a_r4_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && $past(trig_sel) == 2'd0) |-> !$past(bus_rx_ie));

    a_r4_tx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && $past(trig_sel) == 2'd1) |-> !$past(bus_tx_ie));

    a_r5_ack_clears_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && trig_sel == 2'd0 && !bus_rx_set) |=> !rx_flag);

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rx_set |=> rx_flag);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_res && !cnv_res_set[dma_res_idx]) |=> !cnv_flag[$past(dma_res_idx)]);

    a_r11_wav_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr_wav && !wav_set) |=> !wav_flag);

    a_r12_go_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr_go |-> (fl_ready && !fl_busy && fl_wr_req));

    a_r12_hold_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr_req |-> (fl_wr_go != fl_wr_hold));

endmodule

bind dma_trig_hub dma_trig_hub_chk #(.NRES(NRES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_sel   (trig_sel),
    .bus_rx_set (bus_rx_set),
    .bus_rx_ie  (bus_rx_ie),
    .bus_tx_ie  (bus_tx_ie),
    .dma_ack    (dma_ack),
    .cnv_res_set(cnv_res_set),
    .dma_rd_res (dma_rd_res),
    .dma_res_idx(dma_res_idx),
    .wav_set    (wav_set),
    .dma_wr_wav (dma_wr_wav),
    .fl_wr_req  (fl_wr_req),
    .fl_ready   (fl_ready),
    .fl_busy    (fl_busy),
    .dma_req    (dma_req),
    .rx_flag    (rx_flag),
    .cnv_flag   (cnv_flag),
    .wav_flag   (wav_flag),
    .fl_wr_go   (fl_wr_go),
    .fl_wr_hold (fl_wr_hold)
);

// File: tb/dma_trig_hub_tb.sv
`timescale 1ns/1ps
module dma_trig_hub_tb;

    localparam int NRES = 16;
    localparam int IDXW = $clog2(NRES);

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      trig_sel;
    logic            bus_rx_set, bus_rx_ie, bus_tx_set, bus_tx_ie, dma_ack;
    logic [NRES-1:0] cnv_res_set;
    logic            cnv_seq_start, cnv_seq_multi;
    logic [IDXW-1:0] cnv_seq_end, dma_res_idx;
    logic            dma_rd_res, wav_set, dma_wr_wav;
    logic            fl_wr_req, fl_ready, fl_busy;
    logic            dma_req, rx_flag, tx_flag, wav_flag, fl_wr_go, fl_wr_hold;
    logic [NRES-1:0] cnv_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_trig_hub #(.NRES(NRES)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel),
        .bus_rx_set(bus_rx_set), .bus_rx_ie(bus_rx_ie),
        .bus_tx_set(bus_tx_set), .bus_tx_ie(bus_tx_ie), .dma_ack(dma_ack),
        .cnv_res_set(cnv_res_set), .cnv_seq_start(cnv_seq_start),
        .cnv_seq_multi(cnv_seq_multi), .cnv_seq_end(cnv_seq_end),
        .dma_rd_res(dma_rd_res), .dma_res_idx(dma_res_idx),
        .wav_set(wav_set), .dma_wr_wav(dma_wr_wav),
        .fl_wr_req(fl_wr_req), .fl_ready(fl_ready), .fl_busy(fl_busy),
        .dma_req(dma_req), .rx_flag(rx_flag), .tx_flag(tx_flag),
        .cnv_flag(cnv_flag), .wav_flag(wav_flag),
        .fl_wr_go(fl_wr_go), .fl_wr_hold(fl_wr_hold)
    );

    task automatic chk(input string tag, input logic [NRES-1:0] act, input logic [NRES-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; trig_sel = 2'd0;
        bus_rx_set = 0; bus_rx_ie = 0; bus_tx_set = 0; bus_tx_ie = 0; dma_ack = 0;
        cnv_res_set = '0; cnv_seq_start = 0; cnv_seq_multi = 0; cnv_seq_end = '0;
        dma_rd_res = 0; dma_res_idx = '0; wav_set = 0; dma_wr_wav = 0;
        fl_wr_req = 0; fl_ready = 0; fl_busy = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 dma_req", dma_req, 0);
        chk("R1 rx_flag", rx_flag, 0);
        chk("R1 tx_flag", tx_flag, 0);
        chk("R1 cnv_flag", cnv_flag, '0);
        chk("R1 wav_flag", wav_flag, 0);
        chk("R1 fl_wr_go", fl_wr_go, 0);
        chk("R1 fl_wr_hold", fl_wr_hold, 0);
    endtask

    task automatic t_rx_basic();
        trig_sel = 2'd0;
        bus_rx_set = 1; tick(); bus_rx_set = 0;
        chk("R2 rx_flag set", rx_flag, 1);
        chk("R2 no early req", dma_req, 0);
        tick(); chk("R2 req pulse", dma_req, 1);
        tick(); chk("R2 req one cycle", dma_req, 0);
        tick(); chk("R13 no retrigger", dma_req, 0);
        tick(); chk("R13 no retrigger later", dma_req, 0);
        dma_ack = 1; tick(); dma_ack = 0;
        chk("R5 ack clears rx", rx_flag, 0);
        tick(); chk("R5 no req after clear", dma_req, 0);
    endtask

    task automatic t_tx_and_ack_select();
        bus_rx_ie = 1;
        trig_sel = 2'd1;
        bus_rx_set = 1; bus_tx_set = 1; tick(); bus_rx_set = 0; bus_tx_set = 0;
        chk("R3 tx_flag set", tx_flag, 1);
        tick(); chk("R3 req pulse", dma_req, 1);
        tick(); chk("R3 req one cycle", dma_req, 0);
        dma_ack = 1; tick(); dma_ack = 0;
        chk("R5 ack clears tx", tx_flag, 0);
        chk("R5 ack keeps unselected rx", rx_flag, 1);
        trig_sel = 2'd0;
        dma_ack = 1; tick(); dma_ack = 0;
        chk("R5 rx cleared when selected", rx_flag, 0);
        bus_rx_ie = 0;
        tick(); chk("R5 idle", dma_req, 0);
    endtask

    task automatic t_ie_mask();
        trig_sel = 2'd0; bus_rx_ie = 1;
        bus_rx_set = 1; tick(); bus_rx_set = 0;
        for (int i = 0; i < 3; i++) begin
            tick(); chk("R4 masked no req", dma_req, 0);
        end
        chk("R4 flag kept while masked", rx_flag, 1);
        bus_rx_ie = 0; tick();
        chk("R4 req after unmask", dma_req, 1);
        dma_ack = 1; tick(); dma_ack = 0;
        chk("R4 cleanup", rx_flag, 0);
        tick(); chk("R4 idle", dma_req, 0);
    endtask

    task automatic t_set_wins();
        trig_sel = 2'd0;
        bus_rx_set = 1; tick(); bus_rx_set = 0;
        tick(); chk("R6 first req", dma_req, 1);
        tick(); chk("R6 first req ends", dma_req, 0);
        bus_rx_set = 1; dma_ack = 1; tick(); bus_rx_set = 0; dma_ack = 0;
        chk("R6 set beats clear", rx_flag, 1);
        tick(); chk("R6 second req", dma_req, 1);
        tick(); chk("R6 second req ends", dma_req, 0);
        dma_ack = 1; tick(); dma_ack = 0;
        chk("R6 cleanup", rx_flag, 0);
        tick();
    endtask

    task automatic t_cnv_single();
        cnv_seq_multi = 0; cnv_seq_end = IDXW'(5); cnv_seq_start = 1; tick(); cnv_seq_start = 0;
        trig_sel = 2'd2;
        cnv_res_set = NRES'(1) << 3; tick(); cnv_res_set = '0;
        chk("R7 flag3 set", cnv_flag, NRES'(1) << 3);
        tick(); chk("R7 any result triggers", dma_req, 1);
        tick(); chk("R7 req one cycle", dma_req, 0);
        dma_rd_res = 1; dma_res_idx = IDXW'(5); tick(); dma_rd_res = 0;
        chk("R10 other index read keeps flag", cnv_flag, NRES'(1) << 3);
        tick(); chk("R10 no req on foreign read", dma_req, 0);
        dma_rd_res = 1; dma_res_idx = IDXW'(3); tick(); dma_rd_res = 0;
        chk("R10 read clears flag3", cnv_flag, '0);
        tick(); chk("R7 idle", dma_req, 0);
    endtask

    task automatic t_cnv_seq();
        cnv_seq_multi = 1; cnv_seq_end = IDXW'(2); cnv_seq_start = 1; tick(); cnv_seq_start = 0;
        cnv_seq_multi = 0; cnv_seq_end = IDXW'(0);
        trig_sel = 2'd2;
        cnv_res_set = NRES'(1); tick(); cnv_res_set = '0;
        chk("R8 flag0 set", cnv_flag, NRES'(1));
        tick(); chk("R8 non-last no req", dma_req, 0);
        tick(); chk("R9 inputs not captured without start", dma_req, 0);
        cnv_res_set = NRES'(1) << 2; tick(); cnv_res_set = '0;
        tick(); chk("R8 last result triggers", dma_req, 1);
        tick(); chk("R8 req one cycle", dma_req, 0);
        dma_rd_res = 1; dma_res_idx = IDXW'(2); tick();
        chk("R10 read clears flag2 only", cnv_flag, NRES'(1));
        dma_res_idx = IDXW'(0); tick(); dma_rd_res = 0;
        chk("R10 read clears flag0", cnv_flag, '0);
        tick(); chk("R8 idle", dma_req, 0);
    endtask

    task automatic t_wav();
        trig_sel = 2'd3;
        wav_set = 1; tick(); wav_set = 0;
        chk("R11 wav_flag set", wav_flag, 1);
        tick(); chk("R11 req pulse", dma_req, 1);
        tick(); chk("R11 req one cycle", dma_req, 0);
        dma_ack = 1; tick(); dma_ack = 0;
        chk("R11 ack does not clear wav", wav_flag, 1);
        dma_wr_wav = 1; tick(); dma_wr_wav = 0;
        chk("R11 data write clears wav", wav_flag, 0);
        tick(); chk("R11 idle", dma_req, 0);
    endtask

    task automatic t_flash();
        fl_wr_req = 1; fl_ready = 1; fl_busy = 0; #1;
        chk("R12 go when ready", {fl_wr_go, fl_wr_hold}, 2'b10);
        fl_ready = 0; #1;
        chk("R12 hold when not set up", {fl_wr_go, fl_wr_hold}, 2'b01);
        fl_ready = 1; fl_busy = 1; #1;
        chk("R12 hold when busy", {fl_wr_go, fl_wr_hold}, 2'b01);
        fl_wr_req = 0; #1;
        chk("R12 idle without request", {fl_wr_go, fl_wr_hold}, 2'b00);
        fl_busy = 0;
        tick();
    endtask

    initial begin
        #2000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rx_basic();
        t_tx_and_ack_select();
        t_ie_mask();
        t_set_wins();
        t_cnv_single();
        t_cnv_seq();
        t_wav();
        t_flash();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule